// File: doc/BRIEF.md
# Banked GPIO Register File

This block is the register core of a 40-pin general-purpose I/O expander. The pins are grouped into five banks of eight. Each bank has four writable registers: output data, read polarity, direction and interrupt mask. Each bank also has an input view, formed from the synchronised pin levels. A simple bus-side port carries a 6-bit register address, a write strobe and write data. It returns read data combinationally from the addressed register.

On the pin side, the block drives an output value and an output-enable for every pin. A single active-low global enable gates every driver. Three 40-bit vectors are exported to a separate interrupt unit: the synchronised pin levels, the mask bits and the direction bits. The serial protocol engine, the pad cells and the interrupt logic sit outside this block.

The block has no sequencing state machine. Its only sequential elements are the per-bank register flops and a two-stage pin synchroniser.

Top module: `gpx_regfile`

## Requirements
- R1: After reset, reading the registers gives these values: output 0x00, polarity 0x00, direction 0xFF and mask 0xFF in every bank. All pin output-enables are 0.
- R2: Address bits [5:3] select the group: 0 input, 1 output, 2 polarity, 3 direction, 4 mask. Bits [2:0] select bank 0..4. Bank b covers pins 8b..8b+7, and data bit y maps to pin 8b+y.
- R3: A read of the input group returns the synchronised pin level XOR the bank's polarity bits. This holds for pins configured as outputs as well as inputs.
- R4: A read of the output group returns the stored register value, not the pin level.
- R5: A direction bit of 0 makes the pin an output. When the global enable is low, that pin drives its output register bit with output-enable 1. A direction bit of 1 gives output-enable 0.
- R6: While the global enable input is high, every pin output-enable is 0, whatever the direction bits hold.
- R7: A write to any input-group address leaves every register unchanged.
- R8: Reserved addresses are bank offsets 5..7 in any group, and group codes 5..7. They read as 0x00, and writes to them change nothing.
- R9: A pin level change becomes visible to reads on the second rising clock edge after it is applied.
- R10: The exported level vector carries the synchronised, non-inverted pin levels. The exported mask and direction vectors equal the stored mask and direction bits.
- R11: While reset is held low, writes have no effect and registers keep their default values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register address (group in [5:3], bank in [2:0]) |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_in | input | 40 | Pin levels from the pads |
| oe_n | input | 1 | Global active-low output enable |
| pin_out | output | 40 | Output value for each pin |
| pin_drive_en | output | 40 | Output-enable for each pin |
| in_level | output | 40 | Synchronised pin levels for the interrupt unit |
| irq_mask | output | 40 | Mask bits for the interrupt unit |
| dir_input | output | 40 | Direction bits (1 = input) for the interrupt unit |

## Verification
The input path is tried with two settings. First, the same pin pattern is read with polarity zero and then with mixed polarity. Second, pins are read while configured as outputs. Together these separate a true XOR from a direction-gated read. Distinct byte patterns are written to several banks, which exposes swapped bank or group decoding. The output register is read while the pins carry a different pattern, which separates stored data from pin data. Writes are also aimed at input, reserved and during-reset addresses, each followed by full readback. Finally, a pin step is sampled one and two edges after it is applied, to pin down the synchroniser depth.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int ADDR_W = 6;

    typedef enum logic [2:0] {
        GRP_IN  = 3'd0,
        GRP_OUT = 3'd1,
        GRP_POL = 3'd2,
        GRP_DIR = 3'd3,
        GRP_MSK = 3'd4
    } grp_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;
    logic [1:0]   warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
            warm_q   <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
            if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
        end
    end

    assign q = stage2_q;

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (q == $past(d, 2))); // R9
endmodule

// File: rtl/gpx_decode.sv
module gpx_decode
    import gpx_pkg::*;
#(
    parameter int NUM_BANKS = 5
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr,
    output grp_e               grp,
    output logic [2:0]         bank_idx,
    output logic               addr_ok,
    output logic [NUM_BANKS-1:0] we_out,
    output logic [NUM_BANKS-1:0] we_pol,
    output logic [NUM_BANKS-1:0] we_dir,
    output logic [NUM_BANKS-1:0] we_msk
);
    logic grp_ok;

    assign grp      = grp_e'(addr[5:3]);
    assign bank_idx = addr[2:0];

    always_comb begin
        unique case (addr[5:3])
            3'd0, 3'd1, 3'd2, 3'd3, 3'd4: grp_ok = 1'b1;
            default:                      grp_ok = 1'b0;
        endcase
    end

    assign addr_ok = grp_ok && (int'(bank_idx) < NUM_BANKS);

    always_comb begin
        we_out = '0;
        we_pol = '0;
        we_dir = '0;
        we_msk = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (wr && addr_ok && int'(bank_idx) == b) begin
                unique case (addr[5:3])
                    3'd1:    we_out[b] = 1'b1;
                    3'd2:    we_pol[b] = 1'b1;
                    3'd3:    we_dir[b] = 1'b1;
                    3'd4:    we_msk[b] = 1'b1;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_out,
    input  logic         we_pol,
    input  logic         we_dir,
    input  logic         we_msk,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] out_q,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] msk_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            pol_q <= '0;
            dir_q <= '1;
            msk_q <= '1;
        end else begin
            if (we_out) out_q <= wdata;
            if (we_pol) pol_q <= wdata;
            if (we_dir) dir_q <= wdata;
            if (we_msk) msk_q <= wdata;
        end
    end

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we_dir |=> (dir_q == $past(wdata))); // R2
    AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we_out |=> (out_q == $past(wdata))); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_out || we_pol || we_dir || we_msk) |=>
        ($stable(out_q) && $stable(pol_q) && $stable(dir_q) && $stable(msk_q))); // R7
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int BANK_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [BANK_W-1:0]           bus_wdata,
    output logic [BANK_W-1:0]           bus_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
    input  logic                        oe_n,
    output logic [NUM_BANKS*BANK_W-1:0] pin_out,
    output logic [NUM_BANKS*BANK_W-1:0] pin_drive_en,
    output logic [NUM_BANKS*BANK_W-1:0] in_level,
    output logic [NUM_BANKS*BANK_W-1:0] irq_mask,
    output logic [NUM_BANKS*BANK_W-1:0] dir_input
);
    localparam int NPINS = NUM_BANKS * BANK_W;

    grp_e                 grp;
    logic [2:0]           bank_idx;
    logic                 addr_ok;
    logic [NUM_BANKS-1:0] we_out, we_pol, we_dir, we_msk;
    logic [NPINS-1:0]     sync_lvl;
    logic [NPINS-1:0]     out_vec, pol_vec, dir_vec, msk_vec;

    gpx_sync #(.W(NPINS)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_lvl)
    );

    gpx_decode #(.NUM_BANKS(NUM_BANKS)) dec_i (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .grp      (grp),
        .bank_idx (bank_idx),
        .addr_ok  (addr_ok),
        .we_out   (we_out),
        .we_pol   (we_pol),
        .we_dir   (we_dir),
        .we_msk   (we_msk)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpx_bank #(.W(BANK_W)) bank_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .we_out (we_out[b]),
            .we_pol (we_pol[b]),
            .we_dir (we_dir[b]),
            .we_msk (we_msk[b]),
            .wdata  (bus_wdata),
            .out_q  (out_vec[b*BANK_W +: BANK_W]),
            .pol_q  (pol_vec[b*BANK_W +: BANK_W]),
            .dir_q  (dir_vec[b*BANK_W +: BANK_W]),
            .msk_q  (msk_vec[b*BANK_W +: BANK_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr_ok && int'(bank_idx) == b) begin
                unique case (grp)
                    GRP_IN:  bus_rdata = sync_lvl[b*BANK_W +: BANK_W] ^ pol_vec[b*BANK_W +: BANK_W];
                    GRP_OUT: bus_rdata = out_vec[b*BANK_W +: BANK_W];
                    GRP_POL: bus_rdata = pol_vec[b*BANK_W +: BANK_W];
                    GRP_DIR: bus_rdata = dir_vec[b*BANK_W +: BANK_W];
                    GRP_MSK: bus_rdata = msk_vec[b*BANK_W +: BANK_W];
                    default: bus_rdata = '0;
                endcase
            end
        end
    end

    assign pin_out      = out_vec;
    assign pin_drive_en = ~dir_vec & {NPINS{~oe_n}};
    assign in_level     = sync_lvl;
    assign irq_mask     = msk_vec;
    assign dir_input    = dir_vec;

    AST_OE_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (pin_drive_en == '0)); // R6
    AST_RSV_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !addr_ok) |=> ($stable(out_vec) && $stable(pol_vec) &&
                                  $stable(dir_vec) && $stable(msk_vec))); // R8
    AST_IN_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[5:3] == 3'd0) |=> ($stable(out_vec) && $stable(pol_vec) &&
                                              $stable(dir_vec) && $stable(msk_vec))); // R7
    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_ok |-> (bus_rdata == '0)); // R8
endmodule

// File: tb/gpx_regfile_tb.sv
module gpx_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 5;
    localparam int BW = 8;
    localparam int NP = NB * BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic          oe_n = 1'b1;
    logic [NP-1:0] pin_out, pin_drive_en, in_level, irq_mask, dir_input;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpx_regfile #(.NUM_BANKS(NB), .BANK_W(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .oe_n(oe_n),
        .pin_out(pin_out), .pin_drive_en(pin_drive_en), .in_level(in_level),
        .irq_mask(irq_mask), .dir_input(dir_input)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] ad(input int grp, input int bank);
        return 6'((grp << 3) | bank);
    endfunction

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
    endtask

    task automatic t_reset_defaults();
        logic [7:0] d;
        for (int b = 0; b < NB; b++) begin
            rd(ad(1, b), d); chk("R1 out default", d, 8'h00);
            rd(ad(2, b), d); chk("R1 pol default", d, 8'h00);
            rd(ad(3, b), d); chk("R1 dir default", d, 8'hFF);
            rd(ad(4, b), d); chk("R1 msk default", d, 8'hFF);
        end
        oe_n = 1'b0; #1;
        chk("R1 drive_en default", pin_drive_en, '0);
        oe_n = 1'b1;
    endtask

    task automatic t_addr_map();
        logic [7:0] d;
        for (int b = 0; b < NB; b++) wr(ad(1, b), 8'(8'h11 * (b + 1)));
        for (int b = 0; b < NB; b++) wr(ad(2, b), 8'(8'h80 >> b));
        for (int b = 0; b < NB; b++) begin
            rd(ad(1, b), d); chk("R2 out bank", d, 8'(8'h11 * (b + 1)));
            rd(ad(2, b), d); chk("R2 pol bank", d, 8'(8'h80 >> b));
        end
        chk("R2 pin_out bank 3 bits", pin_out[31:24], 8'h44);
        for (int b = 0; b < NB; b++) wr(ad(2, b), 8'h00);
    endtask

    task automatic t_input_polarity();
        logic [7:0] d;
        pin_in = 40'h96_5A_3C_F0_0F;
        settle();
        rd(ad(0, 0), d); chk("R3 in no invert b0", d, 8'h0F);
        rd(ad(0, 4), d); chk("R3 in no invert b4", d, 8'h96);
        wr(ad(2, 1), 8'hFF);
        wr(ad(2, 2), 8'h0F);
        rd(ad(0, 1), d); chk("R3 in invert all", d, 8'h0F);
        rd(ad(0, 2), d); chk("R3 in invert nibble", d, 8'h33);
        wr(ad(3, 2), 8'h00);
        rd(ad(0, 2), d); chk("R3 in while output", d, 8'h33);
        wr(ad(3, 2), 8'hFF);
        wr(ad(2, 1), 8'h00);
        wr(ad(2, 2), 8'h00);
    endtask

    task automatic t_out_readback();
        logic [7:0] d;
        wr(ad(1, 0), 8'hA5);
        pin_in[7:0] = 8'h3C;
        settle();
        rd(ad(1, 0), d); chk("R4 out reg not pin", d, 8'hA5);
        rd(ad(0, 0), d); chk("R4 pin differs", d, 8'h3C);
    endtask

    task automatic t_drive();
        wr(ad(3, 1), 8'h0F);
        wr(ad(1, 1), 8'hC3);
        oe_n = 1'b0; #1;
        chk("R5 drive_en bank1", pin_drive_en[15:8], 8'hF0);
        chk("R5 pin_out bank1", pin_out[15:8], 8'hC3);
        chk("R5 other banks off", {pin_drive_en[39:16], pin_drive_en[7:0]}, '0);
        oe_n = 1'b1; #1;
        chk("R6 oe high tristate", pin_drive_en, '0);
        chk("R6 pin_out kept", pin_out[15:8], 8'hC3);
        wr(ad(3, 1), 8'hFF);
    endtask

    task automatic t_input_write_ignored();
        logic [7:0] d;
        for (int b = 0; b < NB; b++) wr(ad(0, b), 8'h5A);
        rd(ad(1, 0), d); chk("R7 out b0 unchanged", d, 8'hA5);
        rd(ad(2, 0), d); chk("R7 pol b0 unchanged", d, 8'h00);
        rd(ad(3, 0), d); chk("R7 dir b0 unchanged", d, 8'hFF);
        rd(ad(4, 0), d); chk("R7 msk b0 unchanged", d, 8'hFF);
        rd(ad(0, 0), d); chk("R7 in still pin", d, 8'h3C);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        wr(ad(1, 5), 8'hEE);
        wr(ad(3, 7), 8'h00);
        wr(ad(5, 0), 8'h00);
        wr(ad(7, 4), 8'h00);
        rd(ad(1, 5), d); chk("R8 rsv offset read", d, 8'h00);
        rd(ad(6, 1), d); chk("R8 rsv group read", d, 8'h00);
        chk("R8 dir untouched", dir_input, {NP{1'b1}});
        chk("R8 msk untouched", irq_mask, {NP{1'b1}});
        rd(ad(1, 4), d); chk("R8 out b4 untouched", d, 8'h55);
    endtask

    task automatic t_sync_latency();
        logic [7:0] d;
        @(negedge clk);
        pin_in[39:32] = 8'h00;
        settle();
        @(negedge clk);
        pin_in[39:32] = 8'hE7;
        @(posedge clk);
        #1 d = bus_rdata;
        rd(ad(0, 4), d); chk("R9 one edge old", d, 8'h00);
        @(negedge clk);
        #1 d = bus_rdata; chk("R9 two edges new", d, 8'hE7);
    endtask

    task automatic t_vectors();
        wr(ad(2, 3), 8'hFF);
        wr(ad(4, 3), 8'h5A);
        wr(ad(3, 4), 8'h81);
        pin_in[31:24] = 8'h69;
        settle();
        chk("R10 in_level not inverted", in_level[31:24], 8'h69);
        chk("R10 irq_mask", irq_mask[31:24], 8'h5A);
        chk("R10 dir_input", dir_input[39:32], 8'h81);
    endtask

    task automatic t_reset_hold();
        logic [7:0] d;
        @(negedge clk);
        rst_n = 1'b0;
        bus_addr = ad(1, 2); bus_wdata = 8'h77; bus_wr = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        #1 chk("R11 out reset held", pin_out, '0);
        chk("R11 dir reset held", dir_input, {NP{1'b1}});
        rst_n = 1'b1;
        rd(ad(1, 2), d); chk("R11 no write in reset", d, 8'h00);
        rd(ad(4, 3), d); chk("R11 msk back to default", d, 8'hFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_defaults();
        t_addr_map();
        t_input_polarity();
        t_out_readback();
        t_drive();
        t_input_write_ignored();
        t_reserved();
        t_sync_latency();
        t_vectors();
        t_reset_hold();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule